// File: doc/BRIEF.md
# Thread-Qualified Event Counter Unit

One performance-monitoring channel. It counts single-cycle event pulses that arrive with an event code, a sub-event index, a source index, the id of the issuing logical thread (0 or 1) and a privilege flag. Two control registers decide which pulses count. The event-selection register holds the event code, a 16-bit sub-event mask and four per-thread privilege qualifier bits. The counter-configuration register holds the count enable, the source select, the two "must be one" bits, the per-thread overflow-interrupt enables and a sticky overflow flag. A global enable register must also have its bit 7 set before anything counts.

Software preloads the 40-bit counter with the two's complement of the desired period, with the upper bits all ones. The counter then overflows after exactly that many qualified events. On overflow the counter wraps to zero and the sticky flag sets. Each thread has an interrupt line, and a line stays high for as long as the flag is set and that thread's interrupt enable is set. All state is reached through a simple single-cycle register write port and a combinational read port.

Top module: `evq_counter`

## Requirements
- R1: After reset every register, the counter and the overflow flag are zero, both interrupt lines are low, and every read returns zero.
- R2: Register addresses are 0 for event selection, 1 for configuration, 2 for counter bits 31:0, 3 for counter bits 39:32 (read zero-extended), and 4 for global enable. Addresses 5 to 7 read as zero. A write takes effect at the clock edge and reads back from the next cycle. Configuration bit 31 reads the overflow flag and cannot be set by a write.
- R3: An event counts only if global-enable bit 7 is 1, configuration bit 12 is 1 and configuration bits 17:16 are both 1.
- R4: An event counts only if its source index equals configuration bits 15:13, its code equals event-selection bits 30:25, and event-selection bit 9+sub is 1, where sub is the event's 4-bit sub-event index.
- R5: The qualifier bit is event-selection bit 2 for thread 0 user, bit 3 for thread 0 kernel, bit 0 for thread 1 user and bit 1 for thread 1 kernel. An event counts only if its qualifier bit is 1.
- R6: Each qualified event adds one to the 40-bit counter. A counter write in the same cycle replaces the addressed part of the counter, and that event is not counted.
- R7: A qualified event on a counter of all ones wraps it to zero and sets the overflow flag in that same edge. A preload of low word 2^32-N with high byte 0xFF overflows on the Nth event.
- R8: The overflow flag is sticky. A configuration write with bit 31 at 1 leaves it unchanged, and one with bit 31 at 0 clears it. If a wrap happens in the same cycle as a clear, the flag ends up set.
- R9: irqT0 is high while the flag and configuration bit 26 are both set. irqT1 is high while the flag and configuration bit 27 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data of regAddr |
| evtValid | input | 1 | Event pulse present this cycle |
| evtCode | input | 6 | Event code |
| evtSub | input | 4 | Sub-event index into the mask |
| evtSrc | input | 3 | Event source index |
| threadId | input | 1 | Issuing logical thread |
| privKernel | input | 1 | 1 = kernel privilege, 0 = user |
| irqT0 | output | 1 | Overflow interrupt level to thread 0 |
| irqT1 | output | 1 | Overflow interrupt level to thread 1 |

## Verification
The hardest case to reach is the same-cycle conflict between a wrap and a flag clear. The counter must sit at all ones, a qualified event must arrive, and a configuration write with bit 31 at 0 must land in the same cycle. The stimulus gets there by preloading both counter words to all ones directly and then issuing the event and the clearing write in one step. A negated preload of a short period exercises the normal route to overflow. Each qualifier bit is then enabled alone and driven with all four thread and privilege combinations.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 6;
  localparam int SUB_W  = 4;
  localparam int SRC_W  = 3;

  localparam logic [ADDR_W-1:0] A_ESEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CHI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_GEN  = 3'd4;

  localparam int ES_CODE_LSB = 25;
  localparam int ES_MASK_LSB = 9;
  localparam int CF_EN       = 12;
  localparam int CF_SRC_LSB  = 13;
  localparam int CF_REQ_LSB  = 16;
  localparam int CF_IRQ0     = 26;
  localparam int CF_IRQ1     = 27;
  localparam int CF_FLAG     = 31;
  localparam int GEN_BIT     = 7;

  typedef struct packed {
    logic              inc;
    logic              ldLo;
    logic              ldHi;
    logic              flagClr;
    logic [DATA_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              evtValid,
  input  logic [CODE_W-1:0] evtCode,
  input  logic [SUB_W-1:0]  evtSub,
  input  logic [SRC_W-1:0]  evtSrc,
  input  logic              threadId,
  input  logic              privKernel,
  input  logic              ovfFlag,
  input  logic [CNT_W-1:0]  cntVal,
  output strobe_t           strb,
  output logic [DATA_W-1:0] rdData,
  output logic              gateOn,
  output logic              irqT0,
  output logic              irqT1
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] eselReg;
  logic [DATA_W-2:0] cfgReg;
  logic [DATA_W-1:0] genReg;
  logic              qualBit;
  logic              matchAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eselReg <= '0;
      cfgReg  <= '0;
      genReg  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        A_ESEL:  eselReg <= regWrData;
        A_CFG:   cfgReg  <= regWrData[DATA_W-2:0];
        A_GEN:   genReg  <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case ({threadId, privKernel})
      2'b00:   qualBit = eselReg[2];
      2'b01:   qualBit = eselReg[3];
      2'b10:   qualBit = eselReg[0];
      default: qualBit = eselReg[1];
    endcase
  end

  assign gateOn = genReg[GEN_BIT] & cfgReg[CF_EN] & (&cfgReg[CF_REQ_LSB +: 2]);

  assign matchAll = evtValid
                  & (evtSrc == cfgReg[CF_SRC_LSB +: SRC_W])
                  & (evtCode == eselReg[ES_CODE_LSB +: CODE_W])
                  & eselReg[ES_MASK_LSB + int'(evtSub)]
                  & qualBit;

  always_comb begin
    strb.inc     = gateOn & matchAll;
    strb.ldLo    = regWrEn && (regAddr == A_CLO);
    strb.ldHi    = regWrEn && (regAddr == A_CHI);
    strb.flagClr = regWrEn && (regAddr == A_CFG) && !regWrData[CF_FLAG];
    strb.wrData  = regWrData;
  end

  always_comb begin
    case (regAddr)
      A_ESEL:  rdData = eselReg;
      A_CFG:   rdData = {ovfFlag, cfgReg};
      A_CLO:   rdData = cntVal[DATA_W-1:0];
      A_CHI:   rdData = DATA_W'(cntVal[CNT_W-1 -: HI_W]);
      A_GEN:   rdData = genReg;
      default: rdData = '0;
    endcase
  end

  assign irqT0 = ovfFlag & cfgReg[CF_IRQ0];
  assign irqT1 = ovfFlag & cfgReg[CF_IRQ1];
endmodule

// File: rtl/evq_datapath.sv
module evq_datapath
  import evq_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfFlag
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrapNow;

  assign wrapNow = strb.inc && !strb.ldLo && !strb.ldHi && (cntVal == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strb.ldLo) begin
      cntVal[DATA_W-1:0] <= strb.wrData;
    end else if (strb.ldHi) begin
      cntVal[CNT_W-1 -: HI_W] <= strb.wrData[HI_W-1:0];
    end else if (strb.inc) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ovfFlag <= 1'b0;
    else if (wrapNow)      ovfFlag <= 1'b1;
    else if (strb.flagClr) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/evq_counter.sv
module evq_counter
  import evq_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              evtValid,
  input  logic [CODE_W-1:0] evtCode,
  input  logic [SUB_W-1:0]  evtSub,
  input  logic [SRC_W-1:0]  evtSrc,
  input  logic              threadId,
  input  logic              privKernel,
  output logic              irqT0,
  output logic              irqT1
);
  strobe_t          strb;
  logic [CNT_W-1:0] cntVal;
  logic             ovfFlag;
  logic             gateOn;

  evq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .evtValid(evtValid), .evtCode(evtCode),
    .evtSub(evtSub), .evtSrc(evtSrc), .threadId(threadId),
    .privKernel(privKernel), .ovfFlag(ovfFlag), .cntVal(cntVal),
    .strb(strb), .rdData(rdData), .gateOn(gateOn),
    .irqT0(irqT0), .irqT1(irqT1)
  );

  evq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/evq_checker.sv
module evq_checker #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             inc,
  input logic             ldLo,
  input logic             ldHi,
  input logic             flagClr,
  input logic             gateOn,
  input logic [CNT_W-1:0] cntVal,
  input logic             ovfFlag,
  input logic             irqT0,
  input logic             irqT1
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3
  gate_respected_chk: assert property (@(posedge clk) disable iff (!rstN)
    inc |-> gateOn);

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !ldLo && !ldHi && cntVal != CNT_MAX) |=> cntVal == $past(cntVal) + 1'b1);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !ldLo && !ldHi) |=> $stable(cntVal));

  // R7
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !ldLo && !ldHi && cntVal == CNT_MAX) |=> (ovfFlag && cntVal == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);

  // R9
  irq0_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqT0 |-> ovfFlag);

  // R9
  irq1_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqT1 |-> ovfFlag);
endmodule

bind evq_counter evq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inc(strb.inc), .ldLo(strb.ldLo), .ldHi(strb.ldHi),
  .flagClr(strb.flagClr), .gateOn(gateOn), .cntVal(cntVal), .ovfFlag(ovfFlag),
  .irqT0(irqT0), .irqT1(irqT1)
);

// File: tb/evq_counter_test.sv
`timescale 1ns/1ps
module evq_counter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdData;
  logic        evtValid = 1'b0;
  logic [5:0]  evtCode = '0;
  logic [3:0]  evtSub = '0;
  logic [2:0]  evtSrc = '0;
  logic        threadId = 1'b0;
  logic        privKernel = 1'b0;
  logic        irqT0, irqT1;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string curTag  = "R1";

  localparam logic [31:0] ESEL   = 32'h0A00_100F; // code 5, mask bit 3, all qualifiers
  localparam logic [31:0] CFG_ON = 32'h0003_5000; // enable, src 2, required bits
  localparam logic [39:0] MAXV   = '1;

  evq_counter uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rdData(rdData), .evtValid(evtValid),
    .evtCode(evtCode), .evtSub(evtSub), .evtSrc(evtSrc), .threadId(threadId),
    .privKernel(privKernel), .irqT0(irqT0), .irqT1(irqT1)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  logic [31:0] mEsel, mCfg, mGen;
  logic        mFlag;
  logic [39:0] mCnt;
  bit          mHit;
  int          qIdx;

  always @(posedge clk) begin
    if (!rstN) begin
      mEsel <= 0; mCfg <= 0; mGen <= 0; mFlag <= 0; mCnt <= 0;
    end else begin
      qIdx = threadId ? (privKernel ? 1 : 0) : (privKernel ? 3 : 2);
      mHit = evtValid && mGen[7] && mCfg[12] && mCfg[17] && mCfg[16]
             && (evtSrc == mCfg[15:13]) && (evtCode == mEsel[30:25])
             && mEsel[9 + evtSub] && mEsel[qIdx];
      if (regWrEn) begin
        if (regAddr == 0) mEsel <= regWrData;
        if (regAddr == 1) begin
          mCfg <= {1'b0, regWrData[30:0]};
          if (!regWrData[31]) mFlag <= 0;
        end
        if (regAddr == 2) mCnt[31:0] <= regWrData;
        if (regAddr == 3) mCnt[39:32] <= regWrData[7:0];
        if (regAddr == 4) mGen <= regWrData;
      end
      if (mHit && !(regWrEn && (regAddr == 2 || regAddr == 3))) begin
        if (mCnt == MAXV) begin mCnt <= 0; mFlag <= 1; end
        else mCnt <= mCnt + 1;
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mEsel;
      3'd1: return {mFlag, mCfg[30:0]};
      3'd2: return mCnt[31:0];
      3'd3: return {24'b0, mCnt[39:32]};
      3'd4: return mGen;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    nChecks++;
    if (rdData !== expRead(regAddr) || irqT0 !== (mFlag & mCfg[26])
        || irqT1 !== (mFlag & mCfg[27])) begin
      nFails++;
      $display("FAIL %s addr=%0d rdData=%h expected %h irq=%b%b expected %b%b",
               curTag, regAddr, rdData, expRead(regAddr), irqT1, irqT0,
               mFlag & mCfg[27], mFlag & mCfg[26]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d,
                      input bit ev, input logic [5:0] c, input logic [3:0] s,
                      input logic [2:0] src, input bit t, input bit k);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d;
    evtValid = ev; evtCode = c; evtSub = s; evtSrc = src;
    threadId = t; privKernel = k;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [2:0] a);
    step(0, a, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ev(input logic [5:0] c, input logic [3:0] s, input logic [2:0] src,
                    input bit t, input bit k);
    step(0, 3'd2, 0, 1, c, s, src, t, k);
  endtask

  initial begin
    // R1: reset state
    curTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) rd(a[2:0]);

    // R2: write and read back each register
    curTag = "R2";
    wr(0, 32'h1234_5678); rd(0);
    wr(1, 32'hFFFF_FFFF); rd(1);
    wr(1, 32'h0);         rd(1);
    wr(2, 32'hA5A5_A5A5); rd(2);
    wr(3, 32'h1234_5678); rd(3);
    wr(4, 32'h0000_0055); rd(4);
    for (int a = 5; a < 8; a++) rd(a[2:0]);

    // R3: gating by global enable, count enable, required bits
    curTag = "R3";
    wr(0, ESEL); wr(2, 0); wr(3, 0); wr(4, 0); wr(1, CFG_ON);
    repeat (3) ev(5, 3, 2, 0, 0);
    wr(4, 32'h80); wr(1, CFG_ON & ~32'h1000);
    repeat (3) ev(5, 3, 2, 0, 0);
    wr(1, CFG_ON & ~32'h2_0000);
    repeat (3) ev(5, 3, 2, 0, 0);
    wr(1, CFG_ON);
    repeat (4) ev(5, 3, 2, 0, 0);
    rd(2);

    // R4: code, source and mask matching
    curTag = "R4";
    repeat (2) ev(6, 3, 2, 0, 0);
    repeat (2) ev(5, 3, 3, 0, 0);
    repeat (2) ev(5, 4, 2, 1, 1);
    ev(5, 3, 2, 1, 1);
    wr(0, ESEL | 32'h0000_0200); ev(5, 0, 2, 0, 1); rd(2);

    // R5: per-thread privilege qualifiers, one bit at a time
    curTag = "R5";
    for (int q = 0; q < 4; q++) begin
      wr(0, (ESEL & ~32'hF) | (32'h1 << q));
      for (int tk = 0; tk < 4; tk++) ev(5, 3, 2, tk[1], tk[0]);
      rd(2);
    end
    wr(0, ESEL);

    // R6: counter write wins over a simultaneous event
    curTag = "R6";
    step(1, 2, 32'h0000_0100, 1, 5, 3, 2, 0, 0); rd(2);
    step(1, 3, 32'h0000_0042, 1, 5, 3, 2, 0, 0); rd(3);
    repeat (3) ev(5, 3, 2, 1, 0);
    rd(3);

    // R7: negated preload of period 5 overflows on the fifth event
    curTag = "R7";
    wr(2, 32'hFFFF_FFFB); wr(3, 32'hFF); rd(1);
    repeat (4) begin ev(5, 3, 2, 0, 0); rd(1); end
    ev(5, 3, 2, 0, 0); rd(1); rd(2); rd(3);
    ev(5, 3, 2, 0, 0); rd(1);

    // R8: sticky flag, write-one keeps, write-zero clears, wrap beats clear
    curTag = "R8";
    wr(1, CFG_ON | 32'h8000_0000); rd(1);
    wr(1, CFG_ON); rd(1);
    wr(1, CFG_ON | 32'h8000_0000); rd(1);
    wr(2, 32'hFFFF_FFFF); wr(3, 32'hFF);
    step(1, 1, CFG_ON, 1, 5, 3, 2, 0, 0); rd(1); rd(2);

    // R9: interrupt routing per thread
    curTag = "R9";
    wr(1, CFG_ON | 32'h8400_0000); rd(1);
    wr(1, CFG_ON | 32'h8800_0000); rd(1);
    wr(1, CFG_ON | 32'h8C00_0000); rd(1);
    wr(1, CFG_ON | 32'h0C00_0000); rd(1);
    wr(2, 32'hFFFF_FFFE); wr(3, 32'hFF);
    repeat (2) ev(5, 3, 2, 1, 1);
    rd(1); rd(1);

    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule